// File: doc/BRIEF.md
# Masked Service-Request Status Register

This block holds the eight-bit status byte of a measuring instrument and drives its service-request line. Four condition bits come from live instrument events: a reading went out of range, the reading store is full, a conversion has finished, and the command path is idle. A fifth bit is a sticky error flag. It is set by any of several error strobes, or by a trigger that arrives while a conversion is still busy.

A host writes a mask register that uses the same bit layout as the status byte. When a masked status bit rises while no request is pending, the block raises its service request. The request appears on `srq` and as bit 6 of the byte, and the whole byte is frozen as a snapshot. Reading the status byte releases the request and returns the byte to live tracking. The error bit is cleared only by a read of the separate error word, and it latches whether or not a request is enabled for it.

Top module: `srq_status_unit`

## Requirements
- R1: Bits 2 and 7 of `status_byte` always read 0.
- R2: Bit 0 (overflow) is 1 in the cycle after an `ovr_evt` strobe and 0 in the cycle after a `clean_evt` strobe. When both strobe together, the set wins.
- R3: Bit 1 (store full) is 1 once `STORE_DEPTH` `store_evt` strobes (default 100) have been counted. Further store strobes change nothing. A `store_rd` strobe clears the bit in the next cycle.
- R4: Bit 3 (done) is 1 in the cycle after `conv_done`. It is 0 in the cycle after `rd_req` without `conv_done`.
- R5: Bit 4 (ready) shows `cmd_idle` delayed by one clock while no request is pending.
- R6: Bit 5 and `err_flag` become 1 in the cycle after any bit of `err_evt` is high, or after `trig` is high while `conv_busy` is high. `trig` without `conv_busy` has no effect. The flag stays set until an `errw_rd` strobe clears it, and a new error in the same cycle as the clear wins.
- R7: With no request pending, a 0-to-1 change of a status bit whose mask bit is set raises `srq`, and bit 6 of the byte, one clock later. Bit 6 always equals `srq`.
- R8: While a request is pending, `status_byte` holds the value captured when the request was raised. `err_flag` keeps tracking the live error state.
- R9: A `stat_rd` strobe while a request is pending drops `srq` in the next cycle. From then on the byte shows live conditions with bit 6 at 0.
- R10: Only mask bits 0, 1, 3, 4 and 5 take effect. Mask bits 2, 6 and 7 are discarded when written, and a clear mask bit never raises a request.
- R11: While `rst_n` is low, `status_byte` reads 0x00, `srq` is 0 and `err_flag` is 0. Reset also clears the mask.
- R12: With the mask clear, an error sets bit 5 and `err_flag` without raising `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovr_evt | input | 1 | Overrange reading strobe |
| clean_evt | input | 1 | Non-overflowed reading strobe |
| store_evt | input | 1 | Reading written into store strobe |
| store_rd | input | 1 | Stored reading read out strobe |
| conv_done | input | 1 | Conversion complete strobe |
| rd_req | input | 1 | Reading requested strobe |
| cmd_idle | input | 1 | Command path idle level |
| trig | input | 1 | Trigger strobe |
| conv_busy | input | 1 | Conversion in progress level |
| err_evt | input | ERR_W | Error strobes, one per error source |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | Mask write data |
| stat_rd | input | 1 | Status byte read strobe |
| errw_rd | input | 1 | Error word read strobe |
| status_byte | output | 8 | Status byte |
| srq | output | 1 | Service request |
| err_flag | output | 1 | Sticky error flag |

## Verification
The bench drives events while a request is pending and checks that the byte stays frozen. A design that let live bits leak through would show the new overflow bit before the status read. It clears the error word while a request is frozen and then reads the status byte. A design that re-armed on the already-seen bit, or kept bit 6 set after the read, fails here. It writes a mask with only the unused bits set and expects silence on `srq`, which catches a mask that is not filtered. It fills the store exactly to its depth and past it, which exposes an off-by-one counter or a wrapping one. It also pulses a trigger with and without `conv_busy`, which catches an overrun detector that ignores the busy level.

// File: rtl/srq_status_pkg.sv
package srq_status_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_OVF  = 0;
    localparam int BIT_FULL = 1;
    localparam int BIT_DONE = 3;
    localparam int BIT_RDY  = 4;
    localparam int BIT_ERR  = 5;
    localparam int BIT_RQS  = 6;

    // Bits that may cause a service request.
    localparam logic [BYTE_W-1:0] REQ_SRC_MASK = 8'h3B;

    typedef logic [BYTE_W-1:0] stat_byte_t;

endpackage

// File: rtl/srq_cond_track.sv
module srq_cond_track #(
    parameter int STORE_DEPTH = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic clean_evt,
    input  logic store_evt,
    input  logic store_rd,
    input  logic conv_done,
    input  logic rd_req,
    input  logic cmd_idle,
    output logic ovf,
    output logic full,
    output logic done,
    output logic rdy
);

    localparam int CNT_W = $clog2(STORE_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STORE_DEPTH);

    typedef struct packed {
        logic             ovf;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             rdy;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // overflow: set wins over clear
        if (ovr_evt) begin
            st_d.ovf = 1'b1;
        end else if (clean_evt) begin
            st_d.ovf = 1'b0;
        end
        // store occupancy, saturating at depth
        if (store_evt && !store_rd) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (store_rd && !store_evt) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // conversion done: set wins over clear
        if (conv_done) begin
            st_d.done = 1'b1;
        end else if (rd_req) begin
            st_d.done = 1'b0;
        end
        st_d.rdy = cmd_idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf  = st_q.ovf;
    assign full = (st_q.cnt == CNT_MAX);
    assign done = st_q.done;
    assign rdy  = st_q.rdy;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovf); // R2
    AST_OVF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_evt && !ovr_evt) |=> !ovf); // R2
    AST_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rd && !store_evt) |=> !full); // R3
    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !conv_done) |=> !done); // R4
    AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rdy == $past(cmd_idle))); // R5

endmodule

// File: rtl/srq_err_latch.sv
module srq_err_latch #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             trig,
    input  logic             conv_busy,
    input  logic             errw_rd,
    output logic             err
);

    typedef struct packed {
        logic err;
    } err_state_t;

    err_state_t st_d, st_q;
    logic       overrun;
    logic       any_err;

    always_comb begin
        overrun = trig && conv_busy;
        any_err = (|err_evt) || overrun;
        st_d    = st_q;
        if (any_err) begin
            st_d.err = 1'b1;
        end else if (errw_rd) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !errw_rd) |=> err); // R6
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_evt) || (trig && conv_busy)) |=> err); // R6

endmodule

// File: rtl/srq_req_ctrl.sv
module srq_req_ctrl
    import srq_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stat_byte_t live,
    input  logic       mask_we,
    input  stat_byte_t mask_wdata,
    input  logic       stat_rd,
    output stat_byte_t status_byte,
    output logic       srq
);

    typedef struct packed {
        stat_byte_t mask;
        stat_byte_t prev;
        stat_byte_t snap;
        logic       pend;
    } req_state_t;

    req_state_t st_d, st_q;
    stat_byte_t live_src;
    stat_byte_t rises;
    logic       raise;

    always_comb begin
        live_src = live & REQ_SRC_MASK;
        rises    = live_src & ~st_q.prev & st_q.mask;
        raise    = !st_q.pend && (|rises);
        st_d      = st_q;
        st_d.prev = live_src;
        if (mask_we) begin
            st_d.mask = mask_wdata & REQ_SRC_MASK;
        end
        if (raise) begin
            st_d.pend = 1'b1;
            st_d.snap = live_src;
            st_d.snap[BIT_RQS] = 1'b1;
        end else if (st_q.pend && stat_rd) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_byte = st_q.pend ? st_q.snap : live_src;
    assign srq         = st_q.pend;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !stat_rd) |=> $stable(status_byte)); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && stat_rd) |=> !srq); // R9
    AST_RQS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[BIT_RQS] == srq); // R7
    AST_MASK_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mask & ~REQ_SRC_MASK) == '0)); // R10

endmodule

// File: rtl/srq_status_unit.sv
module srq_status_unit
    import srq_status_pkg::*;
#(
    parameter int STORE_DEPTH = 100,
    parameter int ERR_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_evt,
    input  logic             clean_evt,
    input  logic             store_evt,
    input  logic             store_rd,
    input  logic             conv_done,
    input  logic             rd_req,
    input  logic             cmd_idle,
    input  logic             trig,
    input  logic             conv_busy,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             mask_we,
    input  logic [7:0]       mask_wdata,
    input  logic             stat_rd,
    input  logic             errw_rd,
    output logic [7:0]       status_byte,
    output logic             srq,
    output logic             err_flag
);

    logic       ovf, full, done, rdy, err;
    stat_byte_t live;

    srq_cond_track #(
        .STORE_DEPTH(STORE_DEPTH)
    ) i_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_evt  (ovr_evt),
        .clean_evt(clean_evt),
        .store_evt(store_evt),
        .store_rd (store_rd),
        .conv_done(conv_done),
        .rd_req   (rd_req),
        .cmd_idle (cmd_idle),
        .ovf      (ovf),
        .full     (full),
        .done     (done),
        .rdy      (rdy)
    );

    srq_err_latch #(
        .ERR_W(ERR_W)
    ) i_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  (err_evt),
        .trig     (trig),
        .conv_busy(conv_busy),
        .errw_rd  (errw_rd),
        .err      (err)
    );

    always_comb begin
        live           = '0;
        live[BIT_OVF]  = ovf;
        live[BIT_FULL] = full;
        live[BIT_DONE] = done;
        live[BIT_RDY]  = rdy;
        live[BIT_ERR]  = err;
    end

    srq_req_ctrl i_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .stat_rd    (stat_rd),
        .status_byte(status_byte),
        .srq        (srq)
    );

    assign err_flag = err;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[2] == 1'b0) && (status_byte[7] == 1'b0)); // R1
    AST_ERR_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!srq && $rose(err_flag) && !i_req.st_q.mask[BIT_ERR]
         && ((i_req.st_q.mask & live & ~i_req.st_q.prev) == '0)) |=> !srq); // R12

endmodule

// File: tb/test_srq_status_unit.sv
module test_srq_status_unit;

    localparam int ERR_W = 4;
    localparam int DEPTH = 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ovr_evt = 0, clean_evt = 0, store_evt = 0, store_rd = 0;
    logic             conv_done = 0, rd_req = 0, cmd_idle = 1, trig = 0, conv_busy = 0;
    logic [ERR_W-1:0] err_evt = '0;
    logic             mask_we = 0;
    logic [7:0]       mask_wdata = '0;
    logic             stat_rd = 0, errw_rd = 0;
    logic [7:0]       status_byte;
    logic             srq, err_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    srq_status_unit #(.STORE_DEPTH(DEPTH), .ERR_W(ERR_W)) i_srq_status_unit (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .clean_evt(clean_evt),
        .store_evt(store_evt), .store_rd(store_rd), .conv_done(conv_done),
        .rd_req(rd_req), .cmd_idle(cmd_idle), .trig(trig), .conv_busy(conv_busy),
        .err_evt(err_evt), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .stat_rd(stat_rd), .errw_rd(errw_rd), .status_byte(status_byte),
        .srq(srq), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [7:0] v);
        mask_we = 1; mask_wdata = v; tick();
        mask_we = 0; mask_wdata = '0;
    endtask

    task automatic t_reset();
        rst_n = 0; cmd_idle = 1;
        tick(); tick();
        chk("R11 byte in reset", status_byte, 8'h00);
        chk("R11 srq in reset", {7'd0, srq}, 8'h00);
        chk("R11 err in reset", {7'd0, err_flag}, 8'h00);
        rst_n = 1; tick();
        chk("R5 ready after reset", status_byte, 8'h10);
        chk("R1 unused bits zero", status_byte & 8'h84, 8'h00);
    endtask

    task automatic t_overflow();
        ovr_evt = 1; tick(); ovr_evt = 0;
        chk("R2 overflow set", status_byte, 8'h11);
        clean_evt = 1; tick(); clean_evt = 0;
        chk("R2 overflow cleared", status_byte, 8'h10);
        ovr_evt = 1; clean_evt = 1; tick(); ovr_evt = 0; clean_evt = 0;
        chk("R2 set wins", status_byte, 8'h11);
        clean_evt = 1; tick(); clean_evt = 0;
        chk("R2 clear again", status_byte, 8'h10);
    endtask

    task automatic t_done_ready();
        conv_done = 1; tick(); conv_done = 0;
        chk("R4 done set", status_byte, 8'h18);
        rd_req = 1; tick(); rd_req = 0;
        chk("R4 done cleared", status_byte, 8'h10);
        cmd_idle = 0; tick();
        chk("R5 ready drops", status_byte, 8'h00);
        cmd_idle = 1; tick();
        chk("R5 ready returns", status_byte, 8'h10);
    endtask

    task automatic t_store();
        for (int i = 0; i < DEPTH - 1; i++) begin
            store_evt = 1; tick();
        end
        store_evt = 0;
        chk("R3 one short of full", status_byte, 8'h10);
        store_evt = 1; tick(); store_evt = 0;
        chk("R3 full", status_byte, 8'h12);
        store_evt = 1; tick(); store_evt = 0;
        chk("R3 extra store holds full", status_byte, 8'h12);
        store_rd = 1; tick(); store_rd = 0;
        chk("R3 read clears full", status_byte, 8'h10);
        for (int i = 0; i < DEPTH; i++) begin
            store_rd = 1; tick();
        end
        store_rd = 0;
    endtask

    task automatic t_error_nomask();
        err_evt = 4'b0100; tick(); err_evt = '0;
        chk("R12 error bit without mask", status_byte, 8'h30);
        chk("R6 err_flag set", {7'd0, err_flag}, 8'h01);
        tick();
        chk("R12 no srq with clear mask", {7'd0, srq}, 8'h00);
        errw_rd = 1; tick(); errw_rd = 0;
        chk("R6 error word read clears", status_byte, 8'h10);
        trig = 1; tick(); trig = 0;
        chk("R6 trigger while idle ignored", status_byte, 8'h10);
        trig = 1; conv_busy = 1; tick(); trig = 0; conv_busy = 0;
        chk("R6 trigger overrun", status_byte, 8'h30);
        errw_rd = 1; err_evt = 4'b0001; tick(); errw_rd = 0; err_evt = '0;
        chk("R6 new error beats clear", {7'd0, err_flag}, 8'h01);
        errw_rd = 1; tick(); errw_rd = 0;
        chk("R6 cleared again", status_byte, 8'h10);
    endtask

    task automatic t_request();
        write_mask(8'h20);
        err_evt = 4'b1000; tick(); err_evt = '0;
        chk("R7 srq not yet", {7'd0, srq}, 8'h00);
        tick();
        chk("R7 srq raised", {7'd0, srq}, 8'h01);
        chk("R7 byte with rqs", status_byte, 8'h70);
        ovr_evt = 1; tick(); ovr_evt = 0;
        chk("R8 frozen against overflow", status_byte, 8'h70);
        errw_rd = 1; tick(); errw_rd = 0;
        chk("R8 frozen against error clear", status_byte, 8'h70);
        chk("R8 err_flag live", {7'd0, err_flag}, 8'h00);
        stat_rd = 1; tick(); stat_rd = 0;
        chk("R9 srq released", {7'd0, srq}, 8'h00);
        chk("R9 byte live", status_byte, 8'h11);
        tick();
        chk("R9 no re-raise", {7'd0, srq}, 8'h00);
        clean_evt = 1; tick(); clean_evt = 0;
        write_mask(8'h00);
    endtask

    task automatic t_mask();
        write_mask(8'hC4);
        conv_done = 1; tick(); conv_done = 0;
        tick(); tick();
        chk("R10 unused mask bits ignored", {7'd0, srq}, 8'h00);
        chk("R10 byte live", status_byte, 8'h18);
        rd_req = 1; tick(); rd_req = 0;
        write_mask(8'h08);
        conv_done = 1; tick(); conv_done = 0;
        tick();
        chk("R7 done request", {7'd0, srq}, 8'h01);
        chk("R7 done snapshot", status_byte, 8'h58);
        stat_rd = 1; tick(); stat_rd = 0;
        chk("R9 released after done", status_byte, 8'h18);
        rd_req = 1; tick(); rd_req = 0;
        chk("R4 clean end", status_byte, 8'h10);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_overflow();
                t_done_ready();
                t_store();
                t_error_nomask();
                t_request();
                t_mask();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule